// File: doc/BRIEF.md
# Dual-Context Byte DMA Channel

This block is a single DMA channel that moves bytes one at a time between system memory and a byte-wide peripheral port, in either direction. Software holds two buffer descriptors, called context A and context B. Each one names a base address, a byte count and a "final buffer" flag. Software marks either or both descriptors ready in a control word. The engine drains one ready descriptor and clears its ready mark. It then raises that descriptor's completion interrupt and moves on to the other descriptor if that one is ready. Software can therefore refill one buffer while the other one is moving, giving ping-pong operation.

The control word also holds the transfer direction, an enable bit and a channel-reset bit. Clearing the enable bit freezes the channel in place; setting it again resumes from that point. A read-only diagnostic word shows which descriptor is in use, whether the engine is moving data, and how many bytes of the current descriptor are still to go. The engine checks each descriptor before using it. A descriptor that would run past a 4 KB page, or a device-to-memory descriptor whose base is not 64-byte aligned, is refused with a memory-error interrupt and never moves a byte. When a descriptor carrying the final flag drains, the engine sends a one-cycle terminal-count pulse to the device.

Top module: `pingpong_byte_dma`

## Requirements
- R1: The register port decodes four word addresses: 0 is context A, 1 is context B, 2 is control and 3 is diagnostic. A context word holds the base address in bits 31:0, the byte count in bits 43:32 and the final flag in bit 63, and reads back as it was written.
- R2: With control bit 0 clear (memory to device), bytes are read from memory at base, base+1, and so on, and offered to the device in that order. Any base alignment is accepted.
- R3: With control bit 0 set (device to memory), bytes taken from the device are written to memory at base, base+1, and so on, in arrival order.
- R4: When a context finishes, its ready bit is cleared (control bit 4 for A, bit 3 for B) and its own interrupt output pulses for exactly one cycle. At most one interrupt output is high in any cycle.
- R5: After a context finishes, the engine goes straight on to the other context if that one is ready, and otherwise goes idle. After a channel reset, context A is served first when both are ready.
- R6: When the finishing context has its final flag set, the terminal-count output pulses in the same cycle as that context's interrupt. When the flag is clear, it does not pulse.
- R7: While control bit 1 is clear, the channel issues no memory request and offers no device handshake, and its byte counter and address stay put. Setting the bit again resumes the transfer where it stopped.
- R8: While control bit 2 is set, both ready bits, the byte counter and the active flag are held at zero and any memory request or device handshake is withdrawn. The stored context words are left unchanged.
- R9: Diagnostic bit 0 shows the context in use (0 for A, 1 for B). Bit 1 is set while the channel is enabled and busy with a context. Bits 13:2 hold the bytes still to move.
- R10: A context whose base offset within its 4 KB page plus its count exceeds 4096 is refused. The memory-error interrupt pulses, the ready bit clears, no byte moves, and neither the context interrupt nor terminal count fires. A context that ends exactly on the page boundary is accepted.
- R11: In device-to-memory mode, a context whose base has any of bits 5:0 set is refused in the same way as in R10.
- R12: A context with a count of zero completes at once, with no memory request. It raises its interrupt, and it raises terminal count if its final flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data for reg_addr |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the request |
| mem_wdata | output | 8 | Byte to write |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rdata | input | 8 | Read byte, valid with mem_gnt |
| dev_tx_valid | output | 1 | Byte offered to the device |
| dev_tx_data | output | 8 | Byte for the device |
| dev_tx_ready | input | 1 | Device takes the byte |
| dev_rx_valid | input | 1 | Device offers a byte |
| dev_rx_data | input | 8 | Byte from the device |
| dev_rx_ready | output | 1 | Channel takes the byte |
| tc_pulse | output | 1 | Terminal count to the device |
| irq_ctx_a | output | 1 | Context A complete |
| irq_ctx_b | output | 1 | Context B complete |
| irq_mem_err | output | 1 | Context refused |

## Verification
The bench targets the page-boundary check on both sides of the limit. A design that used the wrong comparison would either refuse a buffer that ends exactly at 4096, or start one that runs past it and write into the next page. It runs both contexts back to back with a stalling memory. A design that loses the hand-over would skip context B, serve B first, or pulse terminal count on the wrong context. Freeze and channel reset are applied in the middle of a stalled byte. Those checks catch a counter that keeps moving while frozen, a request that stays up under reset, and a reset that wipes the stored descriptors. Zero-length and misaligned device-to-memory descriptors check that the engine finishes or refuses without touching memory.

// File: rtl/ppdma_pkg.sv
package ppdma_pkg;

    localparam int ADDR_W        = 32;
    localparam int LEN_W         = 12;
    localparam int BYTE_W        = 8;
    localparam int PAGE_BITS     = 12;
    localparam int IN_ALIGN_BITS = 6;
    localparam int NUM_CTX       = 2;
    localparam int WORD_W        = 64;
    localparam int REG_AW        = 2;

    // context word layout
    localparam int BASE_LSB  = 0;
    localparam int LEN_LSB   = 32;
    localparam int FINAL_BIT = 63;

    // control word layout
    localparam int CTL_DIR  = 0;
    localparam int CTL_EN   = 1;
    localparam int CTL_RST  = 2;
    localparam int CTL_BRDY = 3;
    localparam int CTL_ARDY = 4;

    // diagnostic word layout
    localparam int DG_CUR    = 0;
    localparam int DG_ACTIVE = 1;
    localparam int DG_LEFT   = 2;

    localparam logic [REG_AW-1:0] RA_CTX_A = 2'd0;
    localparam logic [REG_AW-1:0] RA_CTX_B = 2'd1;
    localparam logic [REG_AW-1:0] RA_CTRL  = 2'd2;
    localparam logic [REG_AW-1:0] RA_DIAG  = 2'd3;

    typedef struct packed {
        logic              final_buf;
        logic [LEN_W-1:0]  len;
        logic [ADDR_W-1:0] base;
    } ctx_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_RD,
        ST_TX,
        ST_RX,
        ST_WR
    } eng_state_e;

    function automatic ctx_t word_to_ctx(input logic [WORD_W-1:0] w);
        ctx_t c;
        c.base      = w[BASE_LSB +: ADDR_W];
        c.len       = w[LEN_LSB +: LEN_W];
        c.final_buf = w[FINAL_BIT];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] ctx_to_word(input ctx_t c);
        logic [WORD_W-1:0] w;
        w                      = '0;
        w[BASE_LSB +: ADDR_W]  = c.base;
        w[LEN_LSB +: LEN_W]    = c.len;
        w[FINAL_BIT]           = c.final_buf;
        return w;
    endfunction

endpackage

// File: rtl/ppdma_ctx_check.sv
module ppdma_ctx_check
    import ppdma_pkg::*;
#(
    parameter int PB = PAGE_BITS,
    parameter int AB = IN_ALIGN_BITS
) (
    input  ctx_t ctx,
    input  logic to_mem,
    output logic reject
);
    localparam int SUM_W = ((PB > LEN_W) ? PB : LEN_W) + 1;
    localparam logic [SUM_W-1:0] PAGE_SIZE = SUM_W'(1) << PB;

    logic [SUM_W-1:0] end_off;
    logic             crosses_page;
    logic             misaligned;

    assign end_off      = SUM_W'(ctx.base[PB-1:0]) + SUM_W'(ctx.len);
    assign crosses_page = end_off > PAGE_SIZE;
    assign misaligned   = to_mem && (|ctx.base[AB-1:0]);
    assign reject       = crosses_page || misaligned;

endmodule

// File: rtl/ppdma_regs.sv
module ppdma_regs
    import ppdma_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    we,
    input  logic [REG_AW-1:0]       addr,
    input  logic [WORD_W-1:0]       wdata,
    output logic [WORD_W-1:0]       rdata,
    input  logic [NUM_CTX-1:0]      done_clr,
    input  logic                    diag_cur,
    input  logic                    diag_active,
    input  logic [LEN_W-1:0]        diag_left,
    output ctx_t [NUM_CTX-1:0]      ctx_o,
    output logic [NUM_CTX-1:0]      ready_o,
    output logic                    dir_o,
    output logic                    en_o,
    output logic                    chan_rst_o
);
    ctx_t [NUM_CTX-1:0] ctx_q;
    logic [NUM_CTX-1:0] ready_q, ready_n;
    logic dir_q, dir_n, en_q, en_n, crst_q, crst_n;

    for (genvar i = 0; i < NUM_CTX; i++) begin : g_ctx
        always_ff @(posedge clk) begin
            if (rst) begin
                ctx_q[i] <= '0;
            end else if (we && addr == REG_AW'(i)) begin
                ctx_q[i] <= word_to_ctx(wdata);
            end
        end
    end

    always_comb begin
        ready_n = ready_q;
        dir_n   = dir_q;
        en_n    = en_q;
        crst_n  = crst_q;
        if (we && addr == RA_CTRL) begin
            dir_n      = wdata[CTL_DIR];
            en_n       = wdata[CTL_EN];
            crst_n     = wdata[CTL_RST];
            ready_n[0] = wdata[CTL_ARDY];
            ready_n[1] = wdata[CTL_BRDY];
        end
        ready_n = ready_n & ~done_clr;
        if (crst_n) begin
            ready_n = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ready_q <= '0;
            dir_q   <= 1'b0;
            en_q    <= 1'b0;
            crst_q  <= 1'b0;
        end else begin
            ready_q <= ready_n;
            dir_q   <= dir_n;
            en_q    <= en_n;
            crst_q  <= crst_n;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            RA_CTX_A: rdata = ctx_to_word(ctx_q[0]);
            RA_CTX_B: rdata = ctx_to_word(ctx_q[1]);
            RA_CTRL: begin
                rdata[CTL_DIR]  = dir_q;
                rdata[CTL_EN]   = en_q;
                rdata[CTL_RST]  = crst_q;
                rdata[CTL_BRDY] = ready_q[1];
                rdata[CTL_ARDY] = ready_q[0];
            end
            default: begin
                rdata[DG_CUR]              = diag_cur;
                rdata[DG_ACTIVE]           = diag_active;
                rdata[DG_LEFT +: LEN_W]    = diag_left;
            end
        endcase
    end

    assign ctx_o      = ctx_q;
    assign ready_o    = ready_q;
    assign dir_o      = dir_q;
    assign en_o       = en_q;
    assign chan_rst_o = crst_q;

    AST_RST_NO_READY: assert property (@(posedge clk) disable iff (rst)
        crst_q |-> (ready_q == '0)); // R8

endmodule

// File: rtl/ppdma_engine.sv
module ppdma_engine
    import ppdma_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                chan_rst,
    input  logic                en,
    input  logic                dir,
    input  ctx_t [NUM_CTX-1:0]  ctx,
    input  logic [NUM_CTX-1:0]  ready,
    output logic [NUM_CTX-1:0]  done_clr,
    output logic                mem_req,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [BYTE_W-1:0]   mem_wdata,
    input  logic                mem_gnt,
    input  logic [BYTE_W-1:0]   mem_rdata,
    output logic                dev_tx_valid,
    output logic [BYTE_W-1:0]   dev_tx_data,
    input  logic                dev_tx_ready,
    input  logic                dev_rx_valid,
    input  logic [BYTE_W-1:0]   dev_rx_data,
    output logic                dev_rx_ready,
    output logic                tc_pulse,
    output logic                irq_a,
    output logic                irq_b,
    output logic                irq_err,
    output logic                cur_o,
    output logic                active_o,
    output logic [LEN_W-1:0]    left_o
);
    eng_state_e        state_q, state_n;
    logic              cur_q;
    logic [LEN_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] addr_q;
    logic [BYTE_W-1:0] byte_q;
    logic              dir_q, final_q;
    logic              tc_q, irq_a_q, irq_b_q, irq_err_q;
    logic              fin, fin_err, reject, byte_done, cur_final, run;
    ctx_t              sel_ctx;

    assign sel_ctx   = ctx[cur_q];
    assign run       = en && !chan_rst;
    assign cur_final = (state_q == ST_LOAD) ? sel_ctx.final_buf : final_q;
    assign byte_done = run && ((state_q == ST_TX && dev_tx_ready) ||
                               (state_q == ST_WR && mem_gnt));

    ppdma_ctx_check u_check (
        .ctx    (sel_ctx),
        .to_mem (dir),
        .reject (reject)
    );

    always_comb begin
        state_n = state_q;
        fin     = 1'b0;
        fin_err = 1'b0;
        if (run) begin
            unique case (state_q)
                ST_IDLE: if (ready[cur_q] || ready[~cur_q]) state_n = ST_LOAD;
                ST_LOAD: begin
                    if (reject) begin
                        fin     = 1'b1;
                        fin_err = 1'b1;
                    end else if (sel_ctx.len == '0) begin
                        fin = 1'b1;
                    end else begin
                        state_n = dir ? ST_RX : ST_RD;
                    end
                end
                ST_RD: if (mem_gnt) state_n = ST_TX;
                ST_TX: begin
                    if (dev_tx_ready) begin
                        if (cnt_q == LEN_W'(1)) fin = 1'b1;
                        else state_n = ST_RD;
                    end
                end
                ST_RX: if (dev_rx_valid) state_n = ST_WR;
                ST_WR: begin
                    if (mem_gnt) begin
                        if (cnt_q == LEN_W'(1)) fin = 1'b1;
                        else state_n = ST_RX;
                    end
                end
                default: state_n = ST_IDLE;
            endcase
        end
        if (fin) state_n = ST_IDLE;
        done_clr        = '0;
        done_clr[cur_q] = fin;
    end

    always_ff @(posedge clk) begin
        if (rst || chan_rst) begin
            state_q   <= ST_IDLE;
            cur_q     <= 1'b0;
            cnt_q     <= '0;
            addr_q    <= '0;
            byte_q    <= '0;
            dir_q     <= 1'b0;
            final_q   <= 1'b0;
            tc_q      <= 1'b0;
            irq_a_q   <= 1'b0;
            irq_b_q   <= 1'b0;
            irq_err_q <= 1'b0;
        end else begin
            state_q   <= state_n;
            tc_q      <= fin && !fin_err && cur_final;
            irq_a_q   <= fin && !fin_err && !cur_q;
            irq_b_q   <= fin && !fin_err && cur_q;
            irq_err_q <= fin && fin_err;
            unique case (state_q)
                ST_IDLE: if (run && !ready[cur_q] && ready[~cur_q]) cur_q <= ~cur_q;
                ST_LOAD: begin
                    if (run) begin
                        addr_q  <= sel_ctx.base;
                        cnt_q   <= sel_ctx.len;
                        dir_q   <= dir;
                        final_q <= sel_ctx.final_buf;
                    end
                end
                ST_RD: if (run && mem_gnt) byte_q <= mem_rdata;
                ST_RX: if (run && dev_rx_valid) byte_q <= dev_rx_data;
                ST_TX, ST_WR: begin
                    if (byte_done) begin
                        addr_q <= addr_q + ADDR_W'(1);
                        cnt_q  <= cnt_q - LEN_W'(1);
                    end
                end
                default: ;
            endcase
            if (fin) begin
                cur_q <= ~cur_q;
                cnt_q <= '0;
            end
        end
    end

    assign mem_req      = run && (state_q == ST_RD || state_q == ST_WR);
    assign mem_we       = (state_q == ST_WR);
    assign mem_addr     = addr_q;
    assign mem_wdata    = byte_q;
    assign dev_tx_valid = run && state_q == ST_TX;
    assign dev_tx_data  = byte_q;
    assign dev_rx_ready = run && state_q == ST_RX;
    assign tc_pulse     = tc_q;
    assign irq_a        = irq_a_q;
    assign irq_b        = irq_b_q;
    assign irq_err      = irq_err_q;
    assign cur_o        = cur_q;
    assign active_o     = en && state_q != ST_IDLE;
    assign left_o       = cnt_q;

    AST_TC_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        tc_q |-> (irq_a_q || irq_b_q)); // R6
    AST_ONE_IRQ: assert property (@(posedge clk) disable iff (rst)
        $onehot0({irq_a_q, irq_b_q, irq_err_q})); // R4
    AST_ERR_NO_TC: assert property (@(posedge clk) disable iff (rst)
        irq_err_q |-> !tc_q); // R10
    AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (rst || chan_rst)
        !en |=> ($stable(cnt_q) && $stable(addr_q))); // R7
    AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        (mem_req || dev_tx_valid || dev_rx_ready) |-> (en && !chan_rst)); // R8
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst || chan_rst)
        (mem_req && !mem_gnt) |=> (!en || (mem_req && $stable(mem_addr)))); // R2

    logic unused_dir;
    assign unused_dir = dir_q;

endmodule

// File: rtl/pingpong_byte_dma.sv
module pingpong_byte_dma
    import ppdma_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_we,
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic [WORD_W-1:0]   reg_wdata,
    output logic [WORD_W-1:0]   reg_rdata,
    output logic                mem_req,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [BYTE_W-1:0]   mem_wdata,
    input  logic                mem_gnt,
    input  logic [BYTE_W-1:0]   mem_rdata,
    output logic                dev_tx_valid,
    output logic [BYTE_W-1:0]   dev_tx_data,
    input  logic                dev_tx_ready,
    input  logic                dev_rx_valid,
    input  logic [BYTE_W-1:0]   dev_rx_data,
    output logic                dev_rx_ready,
    output logic                tc_pulse,
    output logic                irq_ctx_a,
    output logic                irq_ctx_b,
    output logic                irq_mem_err
);
    ctx_t [NUM_CTX-1:0] ctx;
    logic [NUM_CTX-1:0] ready, done_clr;
    logic               dir, en, chan_rst, cur, active;
    logic [LEN_W-1:0]   left;

    ppdma_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .we          (reg_we),
        .addr        (reg_addr),
        .wdata       (reg_wdata),
        .rdata       (reg_rdata),
        .done_clr    (done_clr),
        .diag_cur    (cur),
        .diag_active (active),
        .diag_left   (left),
        .ctx_o       (ctx),
        .ready_o     (ready),
        .dir_o       (dir),
        .en_o        (en),
        .chan_rst_o  (chan_rst)
    );

    ppdma_engine u_engine (
        .clk          (clk),
        .rst          (rst),
        .chan_rst     (chan_rst),
        .en           (en),
        .dir          (dir),
        .ctx          (ctx),
        .ready        (ready),
        .done_clr     (done_clr),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_gnt      (mem_gnt),
        .mem_rdata    (mem_rdata),
        .dev_tx_valid (dev_tx_valid),
        .dev_tx_data  (dev_tx_data),
        .dev_tx_ready (dev_tx_ready),
        .dev_rx_valid (dev_rx_valid),
        .dev_rx_data  (dev_rx_data),
        .dev_rx_ready (dev_rx_ready),
        .tc_pulse     (tc_pulse),
        .irq_a        (irq_ctx_a),
        .irq_b        (irq_ctx_b),
        .irq_err      (irq_mem_err),
        .cur_o        (cur),
        .active_o     (active),
        .left_o       (left)
    );

endmodule

// File: tb/sim_pingpong_byte_dma.sv
`timescale 1ns/1ps
module sim_pingpong_byte_dma;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_gnt = 1'b1;
    logic [7:0]  mem_rdata;
    logic        dev_tx_valid;
    logic [7:0]  dev_tx_data;
    logic        dev_tx_ready = 1'b1;
    logic        dev_rx_valid = 1'b1;
    logic [7:0]  dev_rx_data;
    logic        dev_rx_ready;
    logic        tc_pulse, irq_ctx_a, irq_ctx_b, irq_mem_err;

    int vectors = 0;
    int miscompares = 0;

    // bench-side models and monitors
    logic [7:0] wmem [256];
    logic [7:0] txbuf [64];
    int   txn, n_req, n_irq_a, n_irq_b, n_err, n_tc, n_tc_a, n_tc_b, first_irq;
    logic [7:0] rx_next = 8'h30;
    bit   rx_pend = 0;
    bit   gnt_mode = 0;
    bit   gnt_tog = 0;
    bit   tx_stall = 0;

    always #4 clk = ~clk;

    assign mem_rdata   = mem_addr[7:0] ^ 8'hA5;
    assign dev_rx_data = rx_next;

    pingpong_byte_dma u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
        .dev_tx_valid(dev_tx_valid), .dev_tx_data(dev_tx_data),
        .dev_tx_ready(dev_tx_ready), .dev_rx_valid(dev_rx_valid),
        .dev_rx_data(dev_rx_data), .dev_rx_ready(dev_rx_ready),
        .tc_pulse(tc_pulse), .irq_ctx_a(irq_ctx_a), .irq_ctx_b(irq_ctx_b),
        .irq_mem_err(irq_mem_err)
    );

    always @(negedge clk) begin
        if (rx_pend) begin
            rx_next = rx_next + 8'd1;
            rx_pend = 0;
        end
        gnt_tog      = ~gnt_tog;
        mem_gnt      = gnt_mode ? gnt_tog : 1'b1;
        dev_tx_ready = !tx_stall;
        if (mem_req) n_req++;
        if (mem_req && mem_gnt && mem_we) wmem[mem_addr[7:0]] = mem_wdata;
        if (dev_tx_valid && dev_tx_ready) begin
            if (txn < 64) txbuf[txn] = dev_tx_data;
            txn++;
        end
        if (dev_rx_ready && dev_rx_valid) rx_pend = 1;
        if (irq_ctx_a) begin n_irq_a++; if (first_irq == 0) first_irq = 1; end
        if (irq_ctx_b) begin n_irq_b++; if (first_irq == 0) first_irq = 2; end
        if (irq_mem_err) n_err++;
        if (tc_pulse) n_tc++;
        if (tc_pulse && irq_ctx_a) n_tc_a++;
        if (tc_pulse && irq_ctx_b) n_tc_b++;
    end

    function automatic logic [63:0] mk_ctx(input logic [31:0] base, input logic [11:0] len,
                                           input logic fin);
        return {fin, 19'b0, len, base};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [63:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [63:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic clr_stats();
        txn = 0; n_req = 0; n_irq_a = 0; n_irq_b = 0; n_err = 0;
        n_tc = 0; n_tc_a = 0; n_tc_b = 0; first_irq = 0;
    endtask

    task automatic wait_done();
        logic [63:0] c, d;
        for (int i = 0; i < 3000; i++) begin
            reg_read(2'd2, c);
            reg_read(2'd3, d);
            if (c[4:3] == 2'b00 && d[1] == 1'b0) break;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset_state();
        logic [63:0] v;
        reg_read(2'd2, v); chk("R8 control after reset", v, 64'h0);
        reg_read(2'd3, v); chk("R9 diagnostic after reset", v, 64'h0);
        chk("R8 no request after reset", {61'b0, mem_req, dev_tx_valid, dev_rx_ready}, 64'h0);
    endtask

    task automatic t_readback();
        logic [63:0] v;
        reg_write(2'd0, mk_ctx(32'h1234_5678, 12'hABC, 1'b1));
        reg_write(2'd1, mk_ctx(32'h0BAD_F00D, 12'h005, 1'b0));
        reg_read(2'd0, v); chk("R1 context A readback", v, mk_ctx(32'h1234_5678, 12'hABC, 1'b1));
        reg_read(2'd1, v); chk("R1 context B readback", v, mk_ctx(32'h0BAD_F00D, 12'h005, 1'b0));
    endtask

    task automatic t_out_single();
        logic [63:0] v;
        clr_stats();
        reg_write(2'd0, mk_ctx(32'h0000_2013, 12'd5, 1'b1));
        reg_write(2'd2, 64'h12);          // A ready, enable, memory to device
        wait_done();
        chk("R2 byte count to device", txn, 5);
        for (int i = 0; i < 5; i++)
            chk("R2 device byte order", txbuf[i], (8'h13 + 8'(i)) ^ 8'hA5);
        chk("R4 irq A pulses once", n_irq_a, 1);
        chk("R6 tc with final flag", n_tc_a, 1);
        reg_read(2'd2, v); chk("R4 ready A cleared", v[4:3], 0);
    endtask

    task automatic t_pingpong_in();
        clr_stats();
        for (int i = 0; i < 256; i++) wmem[i] = 8'h00;
        rx_next  = 8'h30;
        gnt_mode = 1;
        reg_write(2'd2, 64'h04);          // channel reset restores A-first order
        reg_write(2'd0, mk_ctx(32'h0000_3040, 12'd4, 1'b0));
        reg_write(2'd1, mk_ctx(32'h0000_3080, 12'd3, 1'b1));
        reg_write(2'd2, 64'h1B);          // both ready, enable, device to memory
        wait_done();
        gnt_mode = 0;
        for (int i = 0; i < 4; i++) chk("R3 context A memory byte", wmem[8'h40 + i], 8'h30 + 8'(i));
        for (int i = 0; i < 3; i++) chk("R3 context B memory byte", wmem[8'h80 + i], 8'h34 + 8'(i));
        chk("R5 A served before B", first_irq, 1);
        chk("R5 both contexts complete", {n_irq_a[7:0], n_irq_b[7:0]}, 16'h0101);
        chk("R6 tc only with final context B", {n_tc[7:0], n_tc_b[7:0]}, 16'h0101);
    endtask

    task automatic t_freeze();
        logic [63:0] v;
        int held;
        clr_stats();
        tx_stall = 1;
        reg_write(2'd0, mk_ctx(32'h0000_2100, 12'd8, 1'b0));
        reg_write(2'd2, 64'h12);
        repeat (10) @(negedge clk);
        reg_read(2'd3, v); chk("R9 diagnostic busy on A with 8 left", v, 64'h22);
        reg_write(2'd2, 64'h10);          // freeze, A still ready
        tx_stall = 0;
        held = n_req;
        repeat (20) @(negedge clk);
        chk("R7 no device byte while frozen", txn, 0);
        chk("R7 no memory request while frozen", n_req, held);
        reg_read(2'd3, v); chk("R7 counter held, R9 inactive", v, 64'h20);
        reg_write(2'd2, 64'h12);
        wait_done();
        chk("R7 resumed byte count", txn, 8);
        for (int i = 0; i < 8; i++) chk("R7 resumed byte order", txbuf[i], 8'(i) ^ 8'hA5);
        chk("R4 irq A after resume", n_irq_a, 1);
    endtask

    task automatic t_chan_reset();
        logic [63:0] v;
        clr_stats();
        tx_stall = 1;
        reg_write(2'd1, mk_ctx(32'h0000_2200, 12'd6, 1'b1));
        reg_write(2'd2, 64'h0A);          // B ready only, enable
        repeat (10) @(negedge clk);
        reg_read(2'd3, v); chk("R9 diagnostic busy on B with 6 left", v, 64'h1B);
        reg_write(2'd2, 64'h06);          // reset held, enable set
        tx_stall = 0;
        repeat (10) @(negedge clk);
        chk("R8 no device byte under reset", txn, 0);
        chk("R8 handshakes withdrawn", {62'b0, mem_req, dev_tx_valid}, 64'h0);
        reg_read(2'd2, v); chk("R8 ready bits cleared", v[4:3], 0);
        reg_read(2'd3, v); chk("R8 diagnostic cleared", v, 64'h0);
        reg_read(2'd1, v); chk("R8 context B kept", v, mk_ctx(32'h0000_2200, 12'd6, 1'b1));
        chk("R8 no completion under reset", n_irq_b + n_tc, 0);
        reg_write(2'd2, 64'h00);
    endtask

    task automatic t_page();
        logic [63:0] v;
        clr_stats();
        reg_write(2'd0, mk_ctx(32'h0000_4FFE, 12'd4, 1'b1));
        reg_write(2'd1, mk_ctx(32'h0000_4FFC, 12'd4, 1'b0));
        reg_write(2'd2, 64'h1A);
        wait_done();
        chk("R10 crossing context refused", n_err, 1);
        chk("R10 no irq or tc for refused A", n_irq_a + n_tc, 0);
        chk("R10 exact-boundary B moves 4 bytes", txn, 4);
        for (int i = 0; i < 4; i++) chk("R10 boundary byte", txbuf[i], (8'hFC + 8'(i)) ^ 8'hA5);
        chk("R5 B served after refused A", n_irq_b, 1);
        reg_read(2'd2, v); chk("R10 ready bits cleared", v[4:3], 0);
    endtask

    task automatic t_align();
        clr_stats();
        for (int i = 0; i < 256; i++) wmem[i] = 8'h00;
        rx_next = 8'h50;
        reg_write(2'd0, mk_ctx(32'h0000_5004, 12'd2, 1'b0));
        reg_write(2'd1, mk_ctx(32'h0000_5040, 12'd2, 1'b0));
        reg_write(2'd2, 64'h1B);
        wait_done();
        chk("R11 misaligned input refused", n_err, 1);
        chk("R11 refused context left memory alone", {wmem[8'h04], wmem[8'h05]}, 16'h0);
        chk("R11 aligned context written", {wmem[8'h40], wmem[8'h41]}, 16'h5051);
        chk("R11 only B completes", {n_irq_a[7:0], n_irq_b[7:0]}, 16'h0001);
    endtask

    task automatic t_zero_len();
        clr_stats();
        reg_write(2'd1, mk_ctx(32'h0000_6000, 12'd0, 1'b1));
        reg_write(2'd2, 64'h0A);
        wait_done();
        chk("R12 zero-length completes", n_irq_b, 1);
        chk("R12 zero-length honours final flag", n_tc_b, 1);
        chk("R12 zero-length issues no request", n_req + txn, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        clr_stats();
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset_state();
        t_readback();
        t_out_single();
        t_pingpong_in();
        t_freeze();
        t_chan_reset();
        t_page();
        t_align();
        t_zero_len();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule